// File: doc/BRIEF.md
# Third-Order Frame Aligner and Alarm Monitor

This block watches a received 34368 kbit/s NRZ bit stream that is built from frames of 1536 bits. Each frame opens with a 10-bit alignment word, followed by a far-end alarm bit and a national-use bit. The block hunts for the alignment word one bit position at a time and confirms it over several frames before it declares frame lock. Once locked, it watches every alignment word and drops lock after a run of errored words. It also flags an all-ones (AIS) line by counting zeros in fixed windows, and it captures the alarm and national bits of each locked frame.

Serial data arrives as one bit per clock on which `bit_en` is high, so the block runs from a fast system clock with a clock enable. A small host register port gives the current status, a per-status interrupt mask, and two saturating event counters that clear on read: framing errors and loss-of-frame events. A single interrupt line is the OR of all unmasked status bits.

Top module: `e3_frame_monitor`

## Requirements
- R1: After reset, `frame_lost` is 1, `ais_seen`, `far_alarm`, `natl_bit`, `irq` and `host_rdata` are 0, the mask register reads 0x0F, and both counters read 0.
- R2: On each enabled bit, the last 10 received bits are compared with 1111010000 (earliest bit first). While hunting, a match starts confirmation. Lock (`frame_lost` = 0) is declared when three consecutive words match, each FRAME_BITS enabled bits after the one before.
- R3: While locked, four consecutive errored alignment words drop lock, which resumes the bit-by-bit hunt. A single correct word resets the run of errors.
- R4: While locked, the bit right after the alignment word drives `far_alarm` and the bit after that drives `natl_bit`. While out of lock, both keep their last value.
- R5: The framing-error counter (8 bits) adds one for each errored alignment word seen while locked. It stops at 255, and a host read returns its value and clears it. An error in the same cycle as the read leaves it at 1.
- R6: The loss-of-frame counter (8 bits) adds one each time lock is dropped, with the same saturation and clear-on-read behaviour as R5.
- R7: AIS is evaluated over back-to-back windows of FRAME_BITS enabled bits counted from reset. At the last bit of a window, `ais_seen` becomes 1 if the window held fewer than 5 zeros and 0 otherwise.
- R8: One cycle after a change in status or mask, `irq` equals the OR of the status bits whose mask bit is 0. The status layout is bit0 loss of frame, bit1 AIS, bit2 far alarm, bit3 national bit.
- R9: Host address 0 reads status, 1 reads/writes the mask (low four bits), 2 reads the framing-error counter, and 3 reads the loss-of-frame counter. `host_rdata` is loaded on the cycle `host_rd` is high, is valid from the next cycle, and holds otherwise.
- R10: A cycle with `bit_en` low changes no alignment, AIS, or captured-bit state, whatever `bit_in` carries.
- R11: An errored word during confirmation returns the aligner to hunting without counting a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Marks a cycle that carries a received bit |
| bit_in | input | 1 | Received NRZ data bit |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| irq | output | 1 | Interrupt, OR of unmasked status bits |
| frame_lost | output | 1 | 1 while frame alignment is not held |
| ais_seen | output | 1 | All-ones line condition detected |
| far_alarm | output | 1 | Captured far-end alarm bit |
| natl_bit | output | 1 | Captured national-use bit |

## Verification
On every cycle, the assertions check these properties:
- a lock drop is always accompanied by a framing error;
- framing errors are only counted in lock;
- a raised interrupt always traces back to an unmasked status bit;
- idle cycles leave all line status untouched;
- a saturated counter stays put until it is read;
- read data holds between reads.

Some behaviour only the bench scenarios can show. These include the exact lock and unlock frame counts and the return to hunting after a failed confirmation. They also include the 4-versus-5-zero AIS boundary on aligned windows, the capture and hold of the alarm and national bits, and counter saturation at 255 followed by clear-on-read.

// File: rtl/e3fm_pkg.sv
`timescale 1ns/1ps
package e3fm_pkg;
   typedef enum logic [1:0] {
      SY_HUNT    = 2'd0,
      SY_CONFIRM = 2'd1,
      SY_LOCKED  = 2'd2
   } sync_e;

   localparam logic [1:0] RA_STATUS = 2'd0;
   localparam logic [1:0] RA_MASK   = 2'd1;
   localparam logic [1:0] RA_FECNT  = 2'd2;
   localparam logic [1:0] RA_LOFCNT = 2'd3;

   localparam int ST_LOF = 0;
   localparam int ST_AIS = 1;
   localparam int ST_FAR = 2;
   localparam int ST_NAT = 3;
   localparam int ST_W   = 4;
endpackage

// File: rtl/e3fm_align.sv
`timescale 1ns/1ps
module e3fm_align
   import e3fm_pkg::*;
#(
   parameter int              FRAME_BITS = 1536,
   parameter int              FAS_W      = 10,
   parameter logic [FAS_W-1:0] FAS_WORD  = 10'b1111010000,
   parameter int              CONF_N     = 3,
   parameter int              LOSS_N     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   output logic in_frame,
   output logic far_bit,
   output logic nat_bit,
   output logic fe_evt,
   output logic lof_evt
);
   localparam int POS_W  = $clog2(FRAME_BITS);
   localparam int HIT_W  = $clog2(CONF_N + 1);
   localparam int MISS_W = $clog2(LOSS_N + 1);
   localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(FRAME_BITS - 1);
   localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(CONF_N - 1);
   localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_N - 1);

   sync_e              state;
   logic [FAS_W-1:0]   sr, sr_nx;
   logic [POS_W-1:0]   pos;
   logic [HIT_W-1:0]   hits;
   logic [MISS_W-1:0]  miss;
   logic               hit, at_word;

   always_comb begin
      sr_nx   = {sr[FAS_W-2:0], bit_in};
      hit     = (sr_nx == FAS_WORD);
      at_word = (pos == LAST_POS);
      fe_evt  = bit_en && (state == SY_LOCKED) && at_word && !hit;
      lof_evt = fe_evt && (miss == MISS_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SY_HUNT;
         sr      <= '0;
         pos     <= '0;
         hits    <= '0;
         miss    <= '0;
         far_bit <= 1'b0;
         nat_bit <= 1'b0;
      end else if (bit_en) begin
         sr <= sr_nx;
         unique case (state)
            SY_HUNT: begin
               if (hit) begin
                  state <= SY_CONFIRM;
                  hits  <= HIT_W'(1);
                  pos   <= '0;
               end
            end
            SY_CONFIRM: begin
               if (at_word) begin
                  pos <= '0;
                  if (!hit) begin
                     state <= SY_HUNT;
                  end else if (hits == HIT_LAST) begin
                     state <= SY_LOCKED;
                     miss  <= '0;
                  end else begin
                     hits <= hits + 1'b1;
                  end
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            SY_LOCKED: begin
               if (pos == POS_W'(0)) far_bit <= bit_in;
               if (pos == POS_W'(1)) nat_bit <= bit_in;
               if (at_word) begin
                  pos <= '0;
                  if (hit)          miss  <= '0;
                  else if (lof_evt) state <= SY_HUNT;
                  else              miss  <= miss + 1'b1;
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            default: state <= SY_HUNT;
         endcase
      end
   end

   assign in_frame = (state == SY_LOCKED);
endmodule

// File: rtl/e3fm_ais.sv
`timescale 1ns/1ps
module e3fm_ais #(
   parameter int WIN_BITS  = 1536,
   parameter int AIS_ZEROS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   output logic ais
);
   localparam int WPOS_W = $clog2(WIN_BITS);
   localparam int ZC_W   = $clog2(AIS_ZEROS + 1);
   localparam logic [WPOS_W-1:0] WIN_LAST = WPOS_W'(WIN_BITS - 1);
   localparam logic [ZC_W-1:0]   ZC_LIM   = ZC_W'(AIS_ZEROS);

   logic [WPOS_W-1:0] wpos;
   logic [ZC_W-1:0]   zc, zc_tot;

   always_comb begin
      if (zc == ZC_LIM) zc_tot = zc;
      else              zc_tot = zc + ZC_W'(!bit_in);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wpos <= '0;
         zc   <= '0;
         ais  <= 1'b0;
      end else if (bit_en) begin
         if (wpos == WIN_LAST) begin
            wpos <= '0;
            zc   <= '0;
            ais  <= (zc_tot < ZC_LIM);
         end else begin
            wpos <= wpos + 1'b1;
            zc   <= zc_tot;
         end
      end
   end
endmodule

// File: rtl/e3fm_regs.sv
`timescale 1ns/1ps
module e3fm_regs
   import e3fm_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ST_W-1:0]   status,
   input  logic              fe_evt,
   input  logic              lof_evt,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ST_W-1:0]   mask,
   output logic [CNT_W-1:0]  fe_count,
   output logic [CNT_W-1:0]  lof_count,
   output logic              irq
);
   localparam int N_CNT = 2;

   logic [N_CNT-1:0]       evt;
   logic [N_CNT*CNT_W-1:0] cnt_bus;
   logic [DATA_W-1:0]      rsel;

   assign evt = {lof_evt, fe_evt};

   for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
      logic             clr;
      logic [CNT_W-1:0] val;
      assign clr = host_rd && (host_addr == (RA_FECNT + 2'(k)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       val <= '0;
         else if (clr)                     val <= CNT_W'(evt[k]);
         else if (evt[k] && (val != '1))   val <= val + 1'b1;
      end
      assign cnt_bus[k*CNT_W +: CNT_W] = val;
   end

   assign fe_count  = cnt_bus[0 +: CNT_W];
   assign lof_count = cnt_bus[CNT_W +: CNT_W];

   always_comb begin
      unique case (host_addr)
         RA_STATUS: rsel = DATA_W'(status);
         RA_MASK:   rsel = DATA_W'(mask);
         RA_FECNT:  rsel = DATA_W'(fe_count);
         default:   rsel = DATA_W'(lof_count);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
         mask       <= '1;
         irq        <= 1'b0;
      end else begin
         if (host_rd) host_rdata <= rsel;
         if (host_wr && (host_addr == RA_MASK)) mask <= host_wdata[ST_W-1:0];
         irq <= |(status & ~mask);
      end
   end
endmodule

// File: rtl/e3_frame_monitor.sv
`timescale 1ns/1ps
module e3_frame_monitor
   import e3fm_pkg::*;
#(
   parameter int FRAME_BITS = 1536,
   parameter int CONF_N     = 3,
   parameter int LOSS_N     = 4,
   parameter int AIS_ZEROS  = 5,
   parameter int CNT_W      = 8,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              bit_in,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq,
   output logic              frame_lost,
   output logic              ais_seen,
   output logic              far_alarm,
   output logic              natl_bit
);
   localparam int FAS_W = 10;
   localparam logic [FAS_W-1:0] FAS_WORD = 10'b1111010000;

   initial begin : param_chk
      assert (FRAME_BITS > 2*FAS_W + 2) else $fatal(1, "frame too short for alignment word");
      assert (CONF_N >= 2)               else $fatal(1, "confirmation needs at least two words");
      assert (LOSS_N >= 1)               else $fatal(1, "loss run must be positive");
      assert (AIS_ZEROS >= 1 && AIS_ZEROS < FRAME_BITS) else $fatal(1, "AIS zero limit out of range");
      assert (CNT_W >= 1 && CNT_W <= DATA_W) else $fatal(1, "counter wider than host data");
      assert (DATA_W >= ST_W)            else $fatal(1, "host data narrower than status");
   end

   logic              in_frame, fe_evt, lof_evt;
   logic [ST_W-1:0]   status, mask_q;
   logic [CNT_W-1:0]  fe_count, lof_count;

   e3fm_align #(
      .FRAME_BITS(FRAME_BITS), .FAS_W(FAS_W), .FAS_WORD(FAS_WORD),
      .CONF_N(CONF_N), .LOSS_N(LOSS_N)
   ) u_align (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .in_frame(in_frame), .far_bit(far_alarm), .nat_bit(natl_bit),
      .fe_evt(fe_evt), .lof_evt(lof_evt)
   );

   e3fm_ais #(.WIN_BITS(FRAME_BITS), .AIS_ZEROS(AIS_ZEROS)) u_ais (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .ais(ais_seen)
   );

   assign frame_lost       = !in_frame;
   assign status[ST_LOF]   = frame_lost;
   assign status[ST_AIS]   = ais_seen;
   assign status[ST_FAR]   = far_alarm;
   assign status[ST_NAT]   = natl_bit;

   e3fm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .status(status),
      .fe_evt(fe_evt), .lof_evt(lof_evt),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mask(mask_q), .fe_count(fe_count), .lof_count(lof_count), .irq(irq)
   );
endmodule

// File: rtl/e3fm_chk.sv
`timescale 1ns/1ps
module e3fm_chk #(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              host_rd,
   input logic [1:0]        host_addr,
   input logic [DATA_W-1:0] host_rdata,
   input logic              irq,
   input logic              frame_lost,
   input logic              ais_seen,
   input logic              far_alarm,
   input logic              natl_bit,
   input logic [3:0]        mask_q,
   input logic              fe_evt,
   input logic              lof_evt,
   input logic [CNT_W-1:0]  fe_count
);
   logic [3:0] stat;
   assign stat = {natl_bit, far_alarm, ais_seen, frame_lost};

   // R6
   lof_evt_sets_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lof_evt |=> frame_lost);

   // R3
   loss_needs_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_lost) |-> $past(fe_evt));

   // R11
   fe_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fe_evt |-> !frame_lost);

   // R8
   irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> |($past(stat) & ~$past(mask_q)));

   // R5
   fe_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((fe_count == '1) && !(host_rd && host_addr == 2'd2)) |=> (fe_count == '1));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(frame_lost) && $stable(ais_seen) && $stable(far_alarm) && $stable(natl_bit)));

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata));
endmodule

bind e3_frame_monitor e3fm_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .host_rd(host_rd),
   .host_addr(host_addr), .host_rdata(host_rdata), .irq(irq),
   .frame_lost(frame_lost), .ais_seen(ais_seen), .far_alarm(far_alarm),
   .natl_bit(natl_bit), .mask_q(mask_q), .fe_evt(fe_evt), .lof_evt(lof_evt),
   .fe_count(fe_count)
);

// File: tb/e3_frame_monitor_tb.sv
`timescale 1ns/1ps
module e3_frame_monitor_tb;
   localparam int F = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0, bit_in = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       irq, frame_lost, ais_seen, far_alarm, natl_bit;

   int total = 0, bad = 0;
   int nsent = 0;
   bit gappy = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   e3_frame_monitor #(.FRAME_BITS(F)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
      .frame_lost(frame_lost), .ais_seen(ais_seen),
      .far_alarm(far_alarm), .natl_bit(natl_bit)
   );

   // ---------------- reference model ----------------
   int fasv [10] = '{1,1,1,1,0,1,0,0,0,0};
   bit hist [$];
   int m_sync, m_since, m_hits, m_miss, m_wpos, m_zeros, m_fe, m_lofc;
   bit m_far, m_nat, m_ais, m_irq;
   bit [3:0] m_mask;
   bit [7:0] m_rdata;
   bit [3:0] st;
   bit fe_i, lof_i, hit;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist.delete();
         m_sync = 0; m_since = 0; m_hits = 0; m_miss = 0;
         m_wpos = 0; m_zeros = 0; m_fe = 0; m_lofc = 0;
         m_far = 0; m_nat = 0; m_ais = 0; m_irq = 0;
         m_mask = 4'hF; m_rdata = 8'h00;
      end else begin
         st = {m_nat, m_far, m_ais, (m_sync != 2)};
         m_irq = |(st & ~m_mask);
         fe_i = 0; lof_i = 0;
         if (host_rd) begin
            case (host_addr)
               2'd0: m_rdata = {4'h0, st};
               2'd1: m_rdata = {4'h0, m_mask};
               2'd2: m_rdata = 8'(m_fe);
               default: m_rdata = 8'(m_lofc);
            endcase
         end
         if (bit_en) begin
            hist.push_back(bit_in);
            if (hist.size() > 10) void'(hist.pop_front());
            hit = 0;
            if (hist.size() == 10) begin
               hit = 1;
               for (int k = 0; k < 10; k++) if (int'(hist[k]) != fasv[k]) hit = 0;
            end
            if (m_sync == 0) begin
               if (hit) begin m_sync = 1; m_hits = 1; m_since = 0; end
            end else begin
               if (m_sync == 2) begin
                  if (m_since == 0) m_far = bit_in;
                  if (m_since == 1) m_nat = bit_in;
               end
               if (m_since == F-1) begin
                  m_since = 0;
                  if (m_sync == 1) begin
                     if (!hit) m_sync = 0;
                     else begin
                        m_hits++;
                        if (m_hits == 3) begin m_sync = 2; m_miss = 0; end
                     end
                  end else begin
                     if (hit) m_miss = 0;
                     else begin
                        fe_i = 1; m_miss++;
                        if (m_miss == 4) begin m_sync = 0; lof_i = 1; end
                     end
                  end
               end else m_since++;
            end
            if (!bit_in) m_zeros++;
            if (m_wpos == F-1) begin m_ais = (m_zeros < 5); m_zeros = 0; m_wpos = 0; end
            else m_wpos++;
         end
         if (host_rd && host_addr == 2'd2) m_fe = int'(fe_i);
         else if (fe_i && m_fe < 255) m_fe++;
         if (host_rd && host_addr == 2'd3) m_lofc = int'(lof_i);
         else if (lof_i && m_lofc < 255) m_lofc++;
         if (host_wr && host_addr == 2'd1) m_mask = host_wdata[3:0];
      end
   end

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R3 frame_lost vs model", int'(frame_lost), int'(m_sync != 2));
         chk("R7 ais_seen vs model", int'(ais_seen), int'(m_ais));
         chk("R4 far_alarm vs model", int'(far_alarm), int'(m_far));
         chk("R4 natl_bit vs model", int'(natl_bit), int'(m_nat));
         chk("R8 irq vs model", int'(irq), int'(m_irq));
         chk("R9 host_rdata vs model", int'(host_rdata), int'(m_rdata));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic put_bit(input bit b);
      @(negedge clk);
      host_rd = 0; host_wr = 0;
      bit_en = 1; bit_in = b;
      nsent++;
      if (gappy) begin
         @(negedge clk);
         bit_en = 0; bit_in = ~b;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         bit_en = 0; host_rd = 0; host_wr = 0;
      end
   endtask

   task automatic send_frame(input bit good, input bit far, input bit nat);
      for (int k = 0; k < 10; k++) begin
         bit b;
         b = bit'(fasv[k]);
         if (!good && k == 2) b = ~b;
         put_bit(b);
      end
      put_bit(far);
      put_bit(nat);
      for (int k = 12; k < F; k++) put_bit(k % 2 == 0);
   endtask

   task automatic host_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bit_en = 0; host_wr = 0; host_rd = 1; host_addr = a;
      @(negedge clk);
      host_rd = 0;
      d = host_rdata;
   endtask

   task automatic host_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bit_en = 0; host_rd = 0; host_wr = 1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 0;
   endtask

   task automatic ais_window(input int zeros);
      for (int k = 0; k < F; k++) put_bit(!(k >= 10 && k < 10 + zeros));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      logic [7:0] d;
      repeat (5) @(negedge clk);
      rst_n = 1;
      idle(2);
      // R1 reset state
      chk("R1 frame_lost after reset", int'(frame_lost), 1);
      chk("R1 ais after reset", int'(ais_seen), 0);
      chk("R1 irq after reset", int'(irq), 0);
      chk("R1 far/nat after reset", int'({far_alarm, natl_bit}), 0);
      host_read(2'd1, d); chk("R1 mask reset value", int'(d), 8'h0F);
      host_read(2'd2, d); chk("R1 fe counter reset", int'(d), 0);
      host_read(2'd3, d); chk("R1 lof counter reset", int'(d), 0);

      // R2 hunt through junk, R11 confirm failure returns to hunt
      for (int k = 0; k < 36; k++) put_bit(k % 2 == 0);
      send_frame(1, 1, 0);
      send_frame(1, 1, 0);
      idle(2);
      chk("R2 two words do not lock", int'(frame_lost), 1);
      send_frame(0, 1, 0);
      send_frame(1, 1, 0);
      send_frame(1, 1, 0);
      idle(2);
      chk("R11 failed confirm keeps lost", int'(frame_lost), 1);
      send_frame(1, 1, 0);
      idle(2);
      chk("R2 lock after three words", int'(frame_lost), 0);
      chk("R4 far alarm captured", int'(far_alarm), 1);
      chk("R4 national bit captured", int'(natl_bit), 0);
      host_read(2'd2, d); chk("R11 no errors counted before lock", int'(d), 0);

      // R8 unmask loss and AIS
      host_write(2'd1, 8'h0C);
      idle(2);
      chk("R8 irq low while locked", int'(irq), 0);

      // R3 errors below the loss run, R5 counting and clear on read
      send_frame(0, 1, 0);
      send_frame(0, 1, 0);
      send_frame(1, 0, 1);
      idle(2);
      chk("R3 two errors keep lock", int'(frame_lost), 0);
      chk("R4 far alarm updated", int'(far_alarm), 0);
      chk("R4 national bit updated", int'(natl_bit), 1);
      host_read(2'd2, d); chk("R5 fe counter value", int'(d), 2);
      host_read(2'd2, d); chk("R5 fe counter cleared by read", int'(d), 0);
      host_read(2'd0, d); chk("R9 status register", int'(d), 8'h08);

      // R3 four errors drop lock; R4 hold while out of lock
      for (int k = 0; k < 4; k++) send_frame(0, 0, 1);
      send_frame(0, 1, 0);
      idle(2);
      chk("R3 four errors drop lock", int'(frame_lost), 1);
      chk("R8 irq on unmasked loss", int'(irq), 1);
      chk("R4 far held out of lock", int'(far_alarm), 0);
      chk("R4 national held out of lock", int'(natl_bit), 1);
      host_read(2'd3, d); chk("R6 lof counter value", int'(d), 1);
      host_read(2'd2, d); chk("R5 fe counter after loss", int'(d), 4);

      host_write(2'd1, 8'h0F);
      idle(2);
      chk("R8 irq masked", int'(irq), 0);

      // R10 enable gaps while relocking
      gappy = 1;
      for (int k = 0; k < 3; k++) send_frame(1, 1, 1);
      gappy = 0;
      idle(2);
      chk("R10 lock with gapped enable", int'(frame_lost), 0);
      chk("R4 both bits set", int'({far_alarm, natl_bit}), 3);

      // R10 idle cycles with toggling data change nothing
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         bit_en = 0; bit_in = (k % 3 == 0);
      end
      chk("R10 idle keeps lock", int'(frame_lost), 0);
      send_frame(1, 1, 1);
      idle(2);
      chk("R10 alignment intact after idle", int'(frame_lost), 0);
      host_read(2'd2, d); chk("R10 no errors from idle bits", int'(d), 0);

      // R7 AIS windows
      host_write(2'd1, 8'h0D);
      while (nsent % F != 0) put_bit(1);
      ais_window(0);
      ais_window(0);
      idle(2);
      chk("R7 AIS set on all ones", int'(ais_seen), 1);
      chk("R8 irq on unmasked AIS", int'(irq), 1);
      ais_window(4);
      idle(2);
      chk("R7 four zeros keep AIS", int'(ais_seen), 1);
      ais_window(5);
      idle(2);
      chk("R7 five zeros clear AIS", int'(ais_seen), 0);
      ais_window(4);
      idle(2);
      chk("R7 four zeros set AIS again", int'(ais_seen), 1);
      host_write(2'd1, 8'h0F);

      // R5 saturation
      for (int k = 0; k < 3; k++) send_frame(1, 0, 0);
      idle(2);
      chk("R2 relock after AIS", int'(frame_lost), 0);
      chk("R7 AIS cleared by framed data", int'(ais_seen), 0);
      host_read(2'd2, d);
      for (int k = 0; k < 86; k++) begin
         send_frame(0, 0, 0);
         send_frame(0, 0, 0);
         send_frame(0, 0, 0);
         send_frame(1, 0, 0);
      end
      idle(2);
      chk("R3 three-error runs keep lock", int'(frame_lost), 0);
      host_read(2'd2, d); chk("R5 fe counter saturates", int'(d), 255);
      host_read(2'd2, d); chk("R5 saturated counter cleared", int'(d), 0);
      host_read(2'd3, d); chk("R6 one loss during AIS", int'(d), 1);

      idle(3);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule